// File: doc/BRIEF.md
# Capacitor Discharge Fault Detector and Grader

This block watches the current flowing out of the DC-link capacitors of a small DC distribution grid. There is one sensing channel per load zone. A short circuit makes a capacitor dump its charge in a sharp spike, so the block detects a fault from how fast a current rises, not from its level. On every sample strobe it subtracts the previous sample of a channel from the present one. When that rise reaches a programmable detection threshold, the zone is flagged.

A flagged zone is then graded by the magnitude of its present current. Two programmable limits split the grade into no fault, high-impedance fault and low-impedance fault. All channels share one strobe. The results appear one clock later as a flag vector, a packed class vector and a one-cycle valid pulse. Breaker logic downstream consumes these results. Thresholds and a per-channel monitoring mask sit in a small write-only register file. Samples are 16-bit signed fixed point with 8 fractional bits.

Top module: `cap_fault_grader`

## Requirements
- R1: For each channel, the rise index is the present sample minus the previous sample of that channel. The subtraction saturates to +32767 or -32768 and never wraps.
- R2: A channel's flag is 1 only when its monitoring bit is 1 and its rise index, compared as signed, is greater than or equal to the detection threshold. A negative or smaller index gives flag 0 and class 2'b00.
- R3: A flagged channel whose magnitude is at or below the lower grading limit reports class 2'b00.
- R4: A flagged channel whose magnitude is above the lower limit and at or below the upper limit reports class 2'b01 (high impedance).
- R5: A flagged channel whose magnitude is above the upper limit reports class 2'b10 (low impedance). Code 2'b11 never appears.
- R6: A channel whose monitoring-mask bit is 0 always reports flag 0 and class 2'b00. All mask bits are 1 after reset.
- R7: After reset, out_vld, all flags and all classes are 0. The detection threshold resets to 51 (0.2 A), the lower limit to 640 (2.5 A) and the upper limit to 7680 (30 A).
- R8: The first strobe after reset only loads the previous-sample registers. It produces no out_vld pulse.
- R9: Each later strobe gives a one-cycle out_vld pulse on the next cycle, together with new flags and classes. Between strobes the flags and classes hold their values.
- R10: A write with cfg_we high sets a register chosen by cfg_addr: 0 the detection threshold, 1 the lower limit, 2 the upper limit, 3 the monitoring mask (bit i for channel i, from the low bits of cfg_wdata). The new value is used from the following cycle.
- R11: Magnitude is the absolute value of the present sample, so a negative current is graded by its size. The absolute value of -32768 saturates to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select (0 detect, 1 lower, 2 upper, 3 mask) |
| cfg_wdata | input | 16 | Register write data |
| smp_vld | input | 1 | Sample strobe for all channels |
| smp_data | input | 96 | Channel i sample in bits [16i+15:16i], signed Q8.8 |
| out_vld | output | 1 | One-cycle result strobe |
| fault_flag | output | 6 | Per-channel fault flag |
| fault_class | output | 12 | Channel i class in bits [2i+1:2i] |

## Verification
The hardest case to reach from the ports is a rise index that overflows. This needs a channel to swing from full negative to full positive scale on consecutive strobes. Random stimulus close to the thresholds almost never produces that swing, so directed strobes drive the exact extremes. They also drive the exact boundary values of each threshold, under both the reset defaults and rewritten values.

The random part moves each channel by small steps around its previous value and rewrites thresholds and the mask now and then. This covers the grading bands and gaps of varying length between strobes, where the held outputs are checked.

// File: rtl/cap_fault_pkg.sv
// Shared definitions for the capacitor fault grader.
// Assumes: class codes are consumed by downstream breaker logic.
package cap_fault_pkg;

    // Grade of a flagged channel; code 2'b11 is never produced.
    typedef enum logic [1:0] {
        CLS_NONE   = 2'b00,
        CLS_HIGH_Z = 2'b01,
        CLS_LOW_Z  = 2'b10,
        CLS_RSVD   = 2'b11
    } fault_cls_e;

    // Register select codes on the configuration port.
    localparam logic [1:0] ADDR_DETECT = 2'd0;
    localparam logic [1:0] ADDR_LOWER  = 2'd1;
    localparam logic [1:0] ADDR_UPPER  = 2'd2;
    localparam logic [1:0] ADDR_MASK   = 2'd3;

endpackage

// File: rtl/cap_fault_cfg.sv
// Configuration registers: detection threshold, two grading limits and
// the per-channel monitoring mask.
// Assumes: NUM_CH <= DW, so the mask fits in one write word.
module cap_fault_cfg
    import cap_fault_pkg::*;
#(
    parameter int DW     = 16,
    parameter int NUM_CH = 6,
    parameter logic signed [DW-1:0] DET_RST  = 16'sd51,
    parameter logic signed [DW-1:0] LOW_RST  = 16'sd640,
    parameter logic signed [DW-1:0] HIGH_RST = 16'sd7680
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [1:0]           addr,
    input  logic [DW-1:0]        wdata,
    output logic signed [DW-1:0] thr_det,
    output logic signed [DW-1:0] thr_low,
    output logic signed [DW-1:0] thr_high,
    output logic [NUM_CH-1:0]    ch_active
);

    // Register update on writes; defaults restored on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_det   <= DET_RST;
            thr_low   <= LOW_RST;
            thr_high  <= HIGH_RST;
            ch_active <= '1;
        end else if (we) begin
            case (addr)
                ADDR_DETECT: thr_det   <= wdata;
                ADDR_LOWER:  thr_low   <= wdata;
                ADDR_UPPER:  thr_high  <= wdata;
                default:     ch_active <= wdata[NUM_CH-1:0];
            endcase
        end
    end

    // R10: a mask write is visible on the next cycle
    p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_MASK) |=> (ch_active == $past(wdata[NUM_CH-1:0])));

    // R10: a register not addressed keeps its value
    p_det_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADDR_DETECT) |=> $stable(thr_det));

endmodule

// File: rtl/cap_fault_satdiff.sv
// Saturating signed subtraction y = a - b at DW bits.
// Assumes: two's complement operands of equal width.
module cap_fault_satdiff #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] y
);

    localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0] wide;

    // Widen by one bit, subtract, clamp when the top two bits differ.
    always_comb begin
        wide = {a[DW-1], a} - {b[DW-1], b};
        if (wide[DW] != wide[DW-1]) y = wide[DW] ? S_MIN : S_MAX;
        else                        y = wide[DW-1:0];
    end

endmodule

// File: rtl/cap_fault_chan.sv
// One sensing channel: keeps the previous sample, forms the rise index,
// compares it to the detection threshold and grades the magnitude.
// Assumes: all channels share smp_vld; primed is 0 only until the first
// strobe after reset.
module cap_fault_chan
    import cap_fault_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic                 primed,
    input  logic signed [DW-1:0] sample,
    input  logic                 active,
    input  logic signed [DW-1:0] thr_det,
    input  logic signed [DW-1:0] thr_low,
    input  logic signed [DW-1:0] thr_high,
    output logic                 flag,
    output logic [1:0]           cls
);

    localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW-1:0] prev;
    logic signed [DW-1:0] index;
    logic signed [DW-1:0] mag;
    logic                 detect;
    fault_cls_e           grade;

    cap_fault_satdiff #(.DW(DW)) u_diff (
        .a (sample),
        .b (prev),
        .y (index)
    );

    // Saturating absolute value of the present sample.
    always_comb begin
        if (sample == S_MIN)   mag = S_MAX;
        else if (sample < 0)   mag = -sample;
        else                   mag = sample;
    end

    // Detection and three-band grading of the present strobe.
    always_comb begin
        detect = active && (index >= thr_det);
        if (!detect)               grade = CLS_NONE;
        else if (mag > thr_high)   grade = CLS_LOW_Z;
        else if (mag > thr_low)    grade = CLS_HIGH_Z;
        else                       grade = CLS_NONE;
    end

    // History update on every strobe; results only once primed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            flag <= 1'b0;
            cls  <= CLS_NONE;
        end else if (smp_vld) begin
            prev <= sample;
            if (primed) begin
                flag <= detect;
                cls  <= grade;
            end
        end
    end

    // R5: the reserved code never leaves the channel
    p_no_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cls != CLS_RSVD);

    // R2: an index below threshold yields no flag
    p_sub_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && primed && (index < thr_det)) |=> !flag);

    // R2: an unflagged channel carries no class
    p_flag_cls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> (cls == CLS_NONE));

    // R6: a masked channel stays quiet
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !active) |=> (!flag && cls == CLS_NONE));

    // R9: results hold between strobes
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(flag) && $stable(cls)));

    // R1: when a is at least b the saturated index is not negative
    p_index_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample >= prev) |-> (index >= 0));

endmodule

// File: rtl/cap_fault_grader.sv
// Top: capacitor discharge fault detector and grader for NUM_CH zones.
// All channels are sampled on one strobe; results appear one cycle later.
// Assumes: smp_data packs channel i in bits [i*DW +: DW], signed with
// FRAC fractional bits; thresholds use the same format.
module cap_fault_grader
    import cap_fault_pkg::*;
#(
    parameter int DW     = 16,
    parameter int FRAC   = 8,
    parameter int NUM_CH = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_addr,
    input  logic [DW-1:0]          cfg_wdata,
    input  logic                   smp_vld,
    input  logic [NUM_CH*DW-1:0]   smp_data,
    output logic                   out_vld,
    output logic [NUM_CH-1:0]      fault_flag,
    output logic [2*NUM_CH-1:0]    fault_class
);

    // Reset thresholds: 0.2, 2.5 and 30 in the sample format.
    localparam logic signed [DW-1:0] DET_RST  = DW'((1 << FRAC) / 5);
    localparam logic signed [DW-1:0] LOW_RST  = DW'((5 << FRAC) / 2);
    localparam logic signed [DW-1:0] HIGH_RST = DW'(30 << FRAC);

    logic signed [DW-1:0] thr_det;
    logic signed [DW-1:0] thr_low;
    logic signed [DW-1:0] thr_high;
    logic [NUM_CH-1:0]    ch_active;
    logic                 primed;

    cap_fault_cfg #(
        .DW       (DW),
        .NUM_CH   (NUM_CH),
        .DET_RST  (DET_RST),
        .LOW_RST  (LOW_RST),
        .HIGH_RST (HIGH_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .thr_det   (thr_det),
        .thr_low   (thr_low),
        .thr_high  (thr_high),
        .ch_active (ch_active)
    );

    // Marks that a first strobe has loaded the history; gates out_vld.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed  <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= smp_vld && primed;
            if (smp_vld) primed <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        cap_fault_chan #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_vld  (smp_vld),
            .primed   (primed),
            .sample   (smp_data[i*DW +: DW]),
            .active   (ch_active[i]),
            .thr_det  (thr_det),
            .thr_low  (thr_low),
            .thr_high (thr_high),
            .flag     (fault_flag[i]),
            .cls      (fault_class[2*i +: 2])
        );
    end

    // R8: the first strobe after reset yields no result pulse
    p_first_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !primed) |=> !out_vld);

    // R9: a result pulse always follows a strobe by one cycle
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(smp_vld));

    // R9: a primed strobe always produces a result pulse
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && primed) |=> out_vld);

endmodule

// File: tb/cap_fault_grader_bench.sv
module cap_fault_grader_bench;

    localparam int DW = 16;
    localparam int NCH = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_addr = '0;
    logic [DW-1:0]      cfg_wdata = '0;
    logic               smp_vld = 1'b0;
    logic [NCH*DW-1:0]  smp_data = '0;
    logic               out_vld;
    logic [NCH-1:0]     fault_flag;
    logic [2*NCH-1:0]   fault_class;

    cap_fault_grader u_cap_fault_grader (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .smp_data(smp_data),
        .out_vld(out_vld), .fault_flag(fault_flag), .fault_class(fault_class)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    int cur [NCH];
    int prev_m [NCH];
    bit primed_m = 1'b0;
    int det_m = 51, low_m = 640, high_m = 7680;
    bit [NCH-1:0] mask_m = '1;
    bit held_flag [NCH];
    int held_cls [NCH];

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int mag16(int v);
        if (v == -32768) return 32767;
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d[DW-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            2'd0: det_m = d;
            2'd1: low_m = d;
            2'd2: high_m = d;
            default: mask_m = d[NCH-1:0];
        endcase
    endtask

    // Drive cur[] as one strobe, update the model, check next cycle.
    task automatic strobe(int gap);
        bit exp_vld;
        @(negedge clk);
        smp_vld = 1'b1;
        for (int i = 0; i < NCH; i++) smp_data[i*DW +: DW] = cur[i][DW-1:0];
        exp_vld = primed_m;
        if (primed_m) begin
            for (int i = 0; i < NCH; i++) begin
                int idx = sat16(cur[i] - prev_m[i]);
                int m = mag16(cur[i]);
                bit f = mask_m[i] && (idx >= det_m);
                held_flag[i] = f;
                held_cls[i] = !f ? 0 : (m > high_m) ? 2 : (m > low_m) ? 1 : 0;
            end
        end
        for (int i = 0; i < NCH; i++) prev_m[i] = cur[i];
        primed_m = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        chk(out_vld == exp_vld, exp_vld ? "R9 pulse" : "R8 first", out_vld, exp_vld);
        for (int i = 0; i < NCH; i++) begin
            string tag;
            int act = {fault_flag[i], fault_class[2*i +: 2]};
            int exp = {held_flag[i], held_cls[i][1:0]};
            if (!mask_m[i]) tag = "R6";
            else if (!held_flag[i]) tag = "R2";
            else if (held_cls[i] == 2) tag = "R5";
            else if (held_cls[i] == 1) tag = "R4";
            else tag = "R3";
            chk(act == exp, tag, act, exp);
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R9 single pulse", out_vld, 0);
            chk({fault_flag, fault_class} == pack_held(), "R9 hold",
                {fault_flag, fault_class}, pack_held());
        end
    endtask

    function automatic logic [3*NCH-1:0] pack_held();
        logic [3*NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            r[2*NCH + i] = held_flag[i];
            r[2*i +: 2] = held_cls[i][1:0];
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < NCH; i++) begin
            held_flag[i] = 0; held_cls[i] = 0; cur[i] = 0; prev_m[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk(out_vld == 0, "R7 out_vld", out_vld, 0);
        chk(fault_flag == 0, "R7 flags", fault_flag, 0);
        chk(fault_class == 0, "R7 class", fault_class, 0);

        // R8: first strobe loads history only
        strobe(1);
        // R7 defaults at exact boundaries (R2, R3, R4, R5)
        cur = '{51, 50, 641, 640, 7680, 7681};
        strobe(2);
        // falling currents: negative index, no flag (R2)
        cur = '{0, 0, 0, 0, 0, 0};
        strobe(1);
        // R11 negative magnitude; R1 saturation setup
        cur = '{-32768, -32768, 32767, 0, 0, 0};
        strobe(0);
        cur = '{-700, 32767, -32768, -9000, 0, 0};
        strobe(1);
        // R11: |-32768| graded as full scale
        cur = '{-32768, 0, 0, -32768, 0, 0};
        strobe(0);
        cfg_write(2'd0, -32768);
        cur = '{-32768, 0, 0, 0, 0, 0};
        strobe(1);
        cfg_write(2'd0, 51);
        // R6: masked channel ignores a large rise
        cfg_write(2'd3, 6'b111110);
        cur = '{20000, 20000, 0, 0, 0, 0};
        strobe(1);
        cfg_write(2'd3, 6'b111111);
        // R10: rewritten thresholds take effect
        cfg_write(2'd0, 1000);
        cfg_write(2'd1, 100);
        cfg_write(2'd2, 200);
        cur = '{0, 0, 1000, 999, 1100, 1201};
        strobe(1);
        cur = '{1000, 1100, 0, 0, 1100, 0};
        strobe(1);
        cfg_write(2'd0, 51);
        cfg_write(2'd1, 640);
        cfg_write(2'd2, 7680);

        // Random phase
        for (int n = 0; n < 500; n++) begin
            if ($urandom_range(19, 0) == 0) begin
                int d = int'($urandom_range(2000, 1));
                int lo = int'($urandom_range(4000, 0));
                cfg_write(2'd0, d);
                cfg_write(2'd1, lo);
                cfg_write(2'd2, sat16(lo + int'($urandom_range(10000, 0))));
                cfg_write(2'd3, int'($urandom_range(63, 0)));
            end
            for (int i = 0; i < NCH; i++) begin
                if ($urandom_range(15, 0) == 0)
                    cur[i] = int'($urandom_range(65535, 0)) - 32768;
                else
                    cur[i] = sat16(prev_m[i] + int'($urandom_range(9200, 0)) - 200
                                   - ((prev_m[i] > 20000) ? 20000 : 0));
            end
            strobe(int'($urandom_range(2, 0)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule